// File: doc/BRIEF.md
# Microcoded Three-Bus Register Datapath

This block executes one horizontal microinstruction at a time on a 32-bit register-transfer datapath. A microinstruction holds six fields: a memory read strobe, a memory write strobe, three 5-bit register selects (first source bus, second source bus, destination bus), and a 4-bit ALU function. The datapath has a flop-based register file with 31 addressable registers, two source buses, an ALU and a destination bus. A microinstruction register (MIR) captures each accepted microinstruction.

The surrounding control store, sequencer and instruction decoder are outside the block. They present a microinstruction with `uop_valid`. The block takes it on a clock edge where it is idle. It then works through four subcycles in order: control setup, source-bus drive, ALU evaluation, and destination write-back. Two of the registers double as a memory port. The address register always appears on `mem_addr` and the data register on `mem_wdata`. Read data is pulled into the data register one microinstruction after the read was requested.

Top module: `ucode_datapath`

## Requirements
- R1: After reset, `busy`, `mem_rd` and `mem_wr` are 0, and every register holds zero, so `mem_addr` and `mem_wdata` are both 0.
- R2: A microinstruction is taken on a rising edge where `uop_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly four cycles, one per subcycle. `uop_valid` is ignored while `busy` is 1.
- R3: The destination register is written on the edge that ends the fourth subcycle. A register written through the destination bus changes on no other edge.
- R4: Select code 0 puts zero on a source bus. Destination code 0 writes no register.
- R5: Select codes address registers directly: 1 is the program counter, 2 the memory address register (shown on `mem_addr`), 3 the memory data register (shown on `mem_wdata`), and 4 to 31 are general registers (4, 5 and 6 being general A, B and C).
- R6: Arithmetic function codes: 0 is A+B, 1 is the low 32 bits of A×B, 2 is A+1, 3 is B+1, 4 is A−1, 5 is B−1. All wrap modulo 2^32.
- R7: Logic function codes: 6 is A AND B, 7 is A OR B, 8 passes A, and 9 gives the two's complement of A. Codes 10 to 15 pass A unchanged.
- R8: While a microinstruction with the read strobe set is busy, `mem_rd` is 1, with the address register on `mem_addr`. The value on `mem_rdata` is copied into the data register at the end of the first subcycle of the next accepted microinstruction, so that microinstruction can read it on a source bus. The memory must hold `mem_rdata` steady from the end of the read until that copy.
- R9: While a microinstruction with the write strobe set is busy, `mem_wr` is 1, with the address register on `mem_addr` and the data register on `mem_wdata`. A write is completed by keeping the strobe set across two microinstructions: the first loads the data register, the second holds it.
- R10: A register may be both a source and the destination of one microinstruction. The sources are sampled before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uop_valid | input | 1 | Microinstruction present |
| uop_rd | input | 1 | Read strobe field |
| uop_wr | input | 1 | Write strobe field |
| uop_asel | input | 5 | First source bus select |
| uop_bsel | input | 5 | Second source bus select |
| uop_csel | input | 5 | Destination bus select |
| uop_fn | input | 4 | ALU function |
| busy | output | 1 | Microinstruction in progress |
| mem_addr | output | 32 | Address register contents |
| mem_wdata | output | 32 | Data register contents |
| mem_rdata | input | 32 | Read data from memory |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |

## Verification
The address and data registers are visible on the ports all the time. A bad write-back or a bad read fill to either of them shows up one cycle after the edge that caused it. A corrupted general register or program counter stays hidden until a later microinstruction copies it to the data register, which is at least five cycles later. A sequencer that skips or repeats a subcycle shows up at once as a `busy` pulse of the wrong length, or as a port register changing at the wrong point in the microinstruction.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_DRIVE,
    PH_ALU,
    PH_WB
  } phase_e;

  localparam int unsigned FN_ADD   = 0;
  localparam int unsigned FN_MUL   = 1;
  localparam int unsigned FN_INCA  = 2;
  localparam int unsigned FN_INCB  = 3;
  localparam int unsigned FN_DECA  = 4;
  localparam int unsigned FN_DECB  = 5;
  localparam int unsigned FN_AND   = 6;
  localparam int unsigned FN_OR    = 7;
  localparam int unsigned FN_PASSA = 8;
  localparam int unsigned FN_NEGA  = 9;

  localparam int unsigned SEL_PC   = 1;
  localparam int unsigned SEL_MAR  = 2;
  localparam int unsigned SEL_MDR  = 3;

endpackage

// File: rtl/dp_seq.sv
module dp_seq
  import dp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   uop_valid,
  output logic   accept,
  output phase_e phase_q
);

  phase_e phase_d;

  assign accept = (phase_q == PH_IDLE) && uop_valid;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (uop_valid) phase_d = PH_SETUP;
      PH_SETUP: phase_d = PH_DRIVE;
      PH_DRIVE: phase_d = PH_ALU;
      PH_ALU:   phase_d = PH_WB;
      PH_WB:    phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned FNW = 4
) (
  input  logic [FNW-1:0] fn,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  output logic [DW-1:0]  res
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    res = opa;
    case (fn)
      FNW'(FN_ADD):   res = opa + opb;
      FNW'(FN_MUL):   res = opa * opb;
      FNW'(FN_INCA):  res = opa + ONE;
      FNW'(FN_INCB):  res = opb + ONE;
      FNW'(FN_DECA):  res = opa - ONE;
      FNW'(FN_DECB):  res = opb - ONE;
      FNW'(FN_AND):   res = opa & opb;
      FNW'(FN_OR):    res = opa | opb;
      FNW'(FN_PASSA): res = opa;
      FNW'(FN_NEGA):  res = (~opa) + ONE;
      default:        res = opa;
    endcase
  end

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
  import dp_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] asel,
  input  logic [SELW-1:0] bsel,
  input  logic [SELW-1:0] csel,
  input  logic            wb_en,
  input  logic [DW-1:0]   wb_data,
  input  logic            fill_en,
  input  logic [DW-1:0]   fill_data,
  output logic [DW-1:0]   a_bus,
  output logic [DW-1:0]   b_bus,
  output logic [DW-1:0]   mar,
  output logic [DW-1:0]   mdr
);

  localparam int unsigned NREG = 2 ** SELW;

  logic [DW-1:0] rf [NREG];

  // code 0 reads as zero and has no storage
  assign rf[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    logic          en;
    logic          hit;

    assign hit = wb_en && (csel == SELW'(i));

    if (i == SEL_MDR) begin : g_mdr
      always_comb begin
        en = hit || fill_en;
        d  = hit ? wb_data : fill_data;
      end
    end else begin : g_plain
      always_comb begin
        en = hit;
        d  = wb_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign rf[i] = q;
  end

  assign a_bus = rf[asel];
  assign b_bus = rf[bsel];
  assign mar   = rf[SEL_MAR];
  assign mdr   = rf[SEL_MDR];

endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
  import dp_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned SELW = 5,
  parameter int unsigned FNW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uop_valid,
  input  logic            uop_rd,
  input  logic            uop_wr,
  input  logic [SELW-1:0] uop_asel,
  input  logic [SELW-1:0] uop_bsel,
  input  logic [SELW-1:0] uop_csel,
  input  logic [FNW-1:0]  uop_fn,
  output logic            busy,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_rd,
  output logic            mem_wr
);

  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // subcycle sequencer
  phase_e phase_q;
  logic   accept;

  dp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .uop_valid (uop_valid),
    .accept    (accept),
    .phase_q   (phase_q)
  );

  logic setup_ph, drive_ph, alu_ph, wb_ph;
  assign setup_ph = (phase_q == PH_SETUP);
  assign drive_ph = (phase_q == PH_DRIVE);
  assign alu_ph   = (phase_q == PH_ALU);
  assign wb_ph    = (phase_q == PH_WB);

  // microinstruction register
  logic            mir_rd_q,  mir_rd_d;
  logic            mir_wr_q,  mir_wr_d;
  logic [SELW-1:0] mir_a_q,   mir_a_d;
  logic [SELW-1:0] mir_b_q,   mir_b_d;
  logic [SELW-1:0] mir_c_q,   mir_c_d;
  logic [FNW-1:0]  mir_fn_q,  mir_fn_d;

  always_comb begin
    mir_rd_d = mir_rd_q;
    mir_wr_d = mir_wr_q;
    mir_a_d  = mir_a_q;
    mir_b_d  = mir_b_q;
    mir_c_d  = mir_c_q;
    mir_fn_d = mir_fn_q;
    if (accept) begin
      mir_rd_d = uop_rd;
      mir_wr_d = uop_wr;
      mir_a_d  = uop_asel;
      mir_b_d  = uop_bsel;
      mir_c_d  = uop_csel;
      mir_fn_d = uop_fn;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mir_rd_q <= 1'b0;
      mir_wr_q <= 1'b0;
      mir_a_q  <= '0;
      mir_b_q  <= '0;
      mir_c_q  <= '0;
      mir_fn_q <= '0;
    end else begin
      mir_rd_q <= mir_rd_d;
      mir_wr_q <= mir_wr_d;
      mir_a_q  <= mir_a_d;
      mir_b_q  <= mir_b_d;
      mir_c_q  <= mir_c_d;
      mir_fn_q <= mir_fn_d;
    end
  end

  // pending read: set when a read microinstruction retires, used at next setup
  logic rd_pend_q, rd_pend_d;
  logic fill_en;

  assign fill_en = setup_ph && rd_pend_q;

  always_comb begin
    rd_pend_d = rd_pend_q;
    if (setup_ph) rd_pend_d = 1'b0;
    if (wb_ph)    rd_pend_d = mir_rd_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_pend_q <= 1'b0;
    else             rd_pend_q <= rd_pend_d;
  end

  // register file and buses
  logic [DW-1:0] a_bus, b_bus, mar, mdr;
  logic [DW-1:0] res_q, res_d, alu_y;

  dp_regfile #(.DW(DW), .SELW(SELW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .asel      (mir_a_q),
    .bsel      (mir_b_q),
    .csel      (mir_c_q),
    .wb_en     (wb_ph),
    .wb_data   (res_q),
    .fill_en   (fill_en),
    .fill_data (mem_rdata),
    .a_bus     (a_bus),
    .b_bus     (b_bus),
    .mar       (mar),
    .mdr       (mdr)
  );

  // operand latches, loaded at the end of the bus-drive subcycle
  logic [DW-1:0] opa_q, opa_d, opb_q, opb_d;

  always_comb begin
    opa_d = opa_q;
    opb_d = opb_q;
    if (drive_ph) begin
      opa_d = a_bus;
      opb_d = b_bus;
    end
  end

  dp_alu #(.DW(DW), .FNW(FNW)) u_alu (
    .fn  (mir_fn_q),
    .opa (opa_q),
    .opb (opb_q),
    .res (alu_y)
  );

  always_comb begin
    res_d = res_q;
    if (alu_ph) res_d = alu_y;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else begin
      opa_q <= opa_d;
      opb_q <= opb_d;
      res_q <= res_d;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign mem_rd    = busy && mir_rd_q;
  assign mem_wr    = busy && mir_wr_q;
  assign mem_addr  = mar;
  assign mem_wdata = mdr;

endmodule

// File: rtl/dp_check.sv
module dp_check
  import dp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input phase_e        phase,
  input logic          busy,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy); // R2

  AST_MAR_AT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> ($past(phase) == PH_WB)); // R3

  AST_MDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_wdata) |-> ($past(phase) == PH_WB || $past(phase) == PH_SETUP)); // R8

  AST_RD_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy); // R8

  AST_WR_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> busy); // R9

endmodule

bind ucode_datapath dp_check #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .phase     (phase_q),
  .busy      (busy),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/ucode_datapath_tb.sv
module ucode_datapath_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        uop_valid;
  logic        uop_rd, uop_wr;
  logic [4:0]  uop_asel, uop_bsel, uop_csel;
  logic [3:0]  uop_fn;
  logic        busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  int nchk;
  int nerr;
  bit done;

  ucode_datapath u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .uop_valid (uop_valid),
    .uop_rd    (uop_rd),
    .uop_wr    (uop_wr),
    .uop_asel  (uop_asel),
    .uop_bsel  (uop_bsel),
    .uop_csel  (uop_csel),
    .uop_fn    (uop_fn),
    .busy      (busy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: read image filled by the bench, write image filled by the port
  logic [31:0] rd_arr [16];
  logic [31:0] wr_arr [16];

  always @(posedge clk) if (mem_rd) mem_rdata <= rd_arr[mem_addr[3:0]];
  always @(posedge clk) if (mem_wr) wr_arr[mem_addr[3:0]] <= mem_wdata;

  typedef struct packed {
    logic [3:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{4'd0,  32'd5,          32'd7,          32'd12},
    '{4'd1,  32'h0001_0000,  32'h0001_0003,  32'h0003_0000},
    '{4'd2,  32'hFFFF_FFFF,  32'd0,          32'd0},
    '{4'd3,  32'd0,          32'd7,          32'd8},
    '{4'd4,  32'd0,          32'd0,          32'hFFFF_FFFF},
    '{4'd5,  32'd0,          32'd1,          32'd0},
    '{4'd6,  32'hF0F0_1234,  32'h0FF0_FF00,  32'h00F0_1200},
    '{4'd7,  32'hF0F0_1234,  32'h0FF0_FF00,  32'hFFF0_FF34},
    '{4'd8,  32'hDEAD_BEEF,  32'd1,          32'hDEAD_BEEF},
    '{4'd9,  32'd5,          32'd0,          32'hFFFF_FFFB},
    '{4'd12, 32'h0000_1234,  32'h99,         32'h0000_1234},
    '{4'd15, 32'h8000_0000,  32'd0,          32'h8000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic issue(input logic rd, input logic wr, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] c, input logic [3:0] fn);
    @(negedge clk);
    while (busy) @(negedge clk);
    uop_valid = 1'b1;
    uop_rd = rd; uop_wr = wr;
    uop_asel = a; uop_bsel = b; uop_csel = c; uop_fn = fn;
    @(negedge clk);
    uop_valid = 1'b0;
  endtask

  task automatic run(input logic rd, input logic wr, input logic [4:0] a,
                     input logic [4:0] b, input logic [4:0] c, input logic [3:0] fn);
    issue(rd, wr, a, b, c, fn);
    repeat (4) @(negedge clk);
  endtask

  // place a value in a register through a memory read and the data register
  task automatic load(input logic [4:0] r, input logic [31:0] v);
    rd_arr[mem_addr[3:0]] = v;
    run(1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 4'd0);
    run(1'b0, 1'b0, 5'd3, 5'd0, r, 4'd8);
  endtask

  // copy a register into the data register and return what the port shows
  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    run(1'b0, 1'b0, r, 5'd0, 5'd3, 4'd8);
    v = mem_wdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] old_addr, old_data;
    nchk = 0; nerr = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd_arr[i] = 32'd0;
      wr_arr[i] = 32'd0;
    end
    uop_valid = 1'b0; uop_rd = 1'b0; uop_wr = 1'b0;
    uop_asel = '0; uop_bsel = '0; uop_csel = '0; uop_fn = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
    check("R1 mem_wr", {31'd0, mem_wr}, 32'd0);
    check("R1 mem_addr", mem_addr, 32'd0);
    check("R1 mem_wdata", mem_wdata, 32'd0);

    load(5'd4, 32'h11);
    load(5'd5, 32'h22);

    // R2 and R3: busy span, write-back edge, valid ignored while busy
    issue(1'b0, 1'b0, 5'd4, 5'd0, 5'd2, 4'd8);
    check("R2 busy after accept", {31'd0, busy}, 32'd1);
    uop_valid = 1'b1; uop_asel = 5'd5; uop_csel = 5'd2; uop_fn = 4'd8;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 2) uop_valid = 1'b0;
      check("R2 busy mid", {31'd0, busy}, 32'd1);
      check("R3 mar before writeback", mem_addr, 32'd0);
    end
    @(negedge clk);
    check("R2 busy ends", {31'd0, busy}, 32'd0);
    check("R3 mar after writeback", mem_addr, 32'h11);
    repeat (6) @(negedge clk);
    check("R2 valid while busy ignored", mem_addr, 32'h11);

    // R6, R7: operation table
    for (int i = 0; i < 12; i++) begin
      load(5'd4, VEC[i].a);
      load(5'd5, VEC[i].b);
      run(1'b0, 1'b0, 5'd4, 5'd5, 5'd6, VEC[i].fn);
      peek(5'd6, v);
      check((VEC[i].fn < 4'd6) ? "R6 arith" : "R7 logic", v, VEC[i].exp);
    end

    // R4: zero select on source and destination buses
    load(5'd5, 32'h0000_0777);
    run(1'b0, 1'b0, 5'd0, 5'd0, 5'd3, 4'd0);
    check("R4 both sources zero", mem_wdata, 32'd0);
    run(1'b0, 1'b0, 5'd0, 5'd5, 5'd3, 4'd0);
    check("R4 first source zero", mem_wdata, 32'h0000_0777);
    old_addr = mem_addr; old_data = mem_wdata;
    run(1'b0, 1'b0, 5'd5, 5'd0, 5'd0, 4'd2);
    check("R4 no dest keeps mar", mem_addr, old_addr);
    check("R4 no dest keeps mdr", mem_wdata, old_data);

    // R5: program counter and top general register
    load(5'd4, 32'h0000_ABCD);
    run(1'b0, 1'b0, 5'd4, 5'd0, 5'd1, 4'd8);
    peek(5'd1, v);
    check("R5 pc", v, 32'h0000_ABCD);
    run(1'b0, 1'b0, 5'd1, 5'd0, 5'd31, 4'd2);
    peek(5'd31, v);
    check("R5 reg31", v, 32'h0000_ABCE);

    // R10: same register as source and destination
    load(5'd4, 32'd7);
    run(1'b0, 1'b0, 5'd4, 5'd4, 5'd4, 4'd0);
    peek(5'd4, v);
    check("R10 self add", v, 32'd14);

    // R8: read request and fill timing
    rd_arr[mem_addr[3:0]] = 32'hCAFE_F00D;
    issue(1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 4'd0);
    check("R8 rd strobe", {31'd0, mem_rd}, 32'd1);
    check("R8 rd address", mem_addr, 32'h11);
    repeat (4) @(negedge clk);
    check("R8 rd strobe idle", {31'd0, mem_rd}, 32'd0);
    issue(1'b0, 1'b0, 5'd3, 5'd0, 5'd6, 4'd8);
    check("R8 mdr before fill", mem_wdata, 32'd14);
    @(negedge clk);
    check("R8 mdr filled after setup", mem_wdata, 32'hCAFE_F00D);
    repeat (3) @(negedge clk);
    peek(5'd6, v);
    check("R8 read value on bus", v, 32'hCAFE_F00D);

    // R9: two-microinstruction write
    load(5'd4, 32'h0000_5A5A);
    load(5'd5, 32'd3);
    run(1'b0, 1'b0, 5'd5, 5'd0, 5'd2, 4'd8);
    issue(1'b0, 1'b1, 5'd4, 5'd0, 5'd3, 4'd8);
    check("R9 wr strobe", {31'd0, mem_wr}, 32'd1);
    check("R9 wr address", mem_addr, 32'd3);
    repeat (4) @(negedge clk);
    run(1'b0, 1'b1, 5'd0, 5'd0, 5'd0, 4'd0);
    check("R9 wr strobe idle", {31'd0, mem_wr}, 32'd0);
    check("R9 written word", wr_arr[3], 32'h0000_5A5A);

    done = 1'b1;
    summary();
  end

endmodule